// File: doc/BRIEF.md
# Slot Hot-Plug Event Notifier

This block gives system software a small register window through which it learns that a slot has been populated or vacated. When a hot-plug event arrives, the block records which slot changed and in which direction. It raises a bit in a general-purpose event status register and, if software has enabled that source, emits a single-cycle interrupt pulse. Software acknowledges the event by clearing status bits with write-one-to-clear byte writes. It reads two slot bitmaps, one for arrivals and one for departures.

When software has finished taking a device out of service, it writes a word to an eject register. The block turns the lowest set bit of that word into a slot index. It reports the index on a one-cycle completion strobe for the surrounding platform logic.

The register bus is a simple single-cycle port. A write takes effect at the clock edge where the write strobe is high. Read data is combinational on the address. Byte-wide registers sit at byte offsets and return their byte in the low eight bits of the read word.

Top module: `hotplug_notifier`

## Requirements
- R1: After synchronous reset, every register (event status, event enable, both slot bitmaps) reads 0, and the interrupt pulse and eject completion outputs are low.
- R2: The 16-bit event status register is accessed one byte at a time: offset 0 is bits 7:0 and offset 1 is bits 15:8. A write clears, in the addressed byte only, each bit that is 1 in write data bits 7:0. The other byte is unchanged.
- R3: The 16-bit event enable register sits at offset 2 (bits 7:0) and offset 3 (bits 15:8). A write replaces the addressed byte with write data bits 7:0 and leaves the other byte unchanged.
- R4: A read of offsets 0 to 3 returns the addressed byte in read data bits 7:0, with bits 31:8 zero. A read of an unmapped offset (for example 0x08 or 0x1C) returns 0.
- R5: The arrival bitmap at offset 0x10 and the departure bitmap at offset 0x14 are 32-bit registers. Each is written and read back as a whole word.
- R6: A hot-plug event first zeroes both bitmaps. It then sets bit [slot] of the arrival bitmap for an insertion (insert flag 1), or of the departure bitmap for a removal (insert flag 0). It also sets event status bit 1. All of these are visible after the event's clock edge.
- R7: If event enable bit 1 is 1 in the cycle of a hot-plug event, the interrupt output is high for exactly the one cycle after that edge. If enable bit 1 is 0, the interrupt stays low.
- R8: A nonzero write to the eject register at offset 0x18 drives the completion strobe high for the one cycle after the write edge. In that cycle the slot output holds the index of the lowest set bit of the written word. A read of offset 0x18 returns 0.
- R9: A write of zero to the eject register produces no completion strobe.
- R10: When a hot-plug event coincides with a register write, the event wins. Status bit 1 ends set even if the write clears it, and a bitmap write in the same cycle is overridden by the event's clear-and-set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hp_valid | input | 1 | Hot-plug event strobe |
| hp_slot | input | 5 | Slot number of the event |
| hp_insert | input | 1 | 1 for insertion, 0 for removal |
| irq_pulse | output | 1 | One-cycle interrupt request |
| eject_done | output | 1 | One-cycle eject completion strobe |
| eject_slot | output | 5 | Slot index reported with eject_done |

## Verification
A corrupted status or enable byte shows up at the next byte read of that offset. A flip in enable bit 1 also shows up on the very next hot-plug event, as a missing or spurious interrupt one cycle after the event edge. A bitmap that is not wiped before the new bit is set shows extra ones on the first read after the event. A wrong priority-encoder index shows up as a bad eject_slot in the single cycle that follows the eject write. The bench therefore samples each strobe exactly one edge after its cause, and it reads back every register after each stimulus.

// File: rtl/hpn_pkg.sv
package hpn_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] OFF_ARRIVE = 8'h10;
    localparam logic [7:0] OFF_DEPART = 8'h14;
    localparam logic [7:0] OFF_EJECT  = 8'h18;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_STAT   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ARRIVE = 3'd3,
        SEL_DEPART = 3'd4,
        SEL_EJECT  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
    } bus_dec_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off,
                                               input int unsigned lanes);
        reg_sel_e r;
        if (off < 8'(lanes))            r = SEL_STAT;
        else if (off < 8'(2 * lanes))   r = SEL_ENABLE;
        else if (off == OFF_ARRIVE)     r = SEL_ARRIVE;
        else if (off == OFF_DEPART)     r = SEL_DEPART;
        else if (off == OFF_EJECT)      r = SEL_EJECT;
        else                            r = SEL_NONE;
        return r;
    endfunction

endpackage

// File: rtl/hpn_event_regs.sv
module hpn_event_regs #(
    parameter int unsigned EV_W   = 16,
    parameter int unsigned HP_BIT = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [EV_W/hpn_pkg::BYTE_W-1:0] stat_wr_i,
    input  logic [EV_W/hpn_pkg::BYTE_W-1:0] en_wr_i,
    input  logic [hpn_pkg::BYTE_W-1:0]    wbyte_i,
    input  logic                          set_hp_i,
    output logic [EV_W-1:0]               status_o,
    output logic [EV_W-1:0]               enable_o
);
    import hpn_pkg::*;

    localparam int unsigned LANES = EV_W / BYTE_W;

    logic [EV_W-1:0] status_q, enable_q;
    logic [EV_W-1:0] status_lane_d, enable_d, status_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign status_lane_d[l*BYTE_W +: BYTE_W] = stat_wr_i[l]
            ? (status_q[l*BYTE_W +: BYTE_W] & ~wbyte_i)
            : status_q[l*BYTE_W +: BYTE_W];
        assign enable_d[l*BYTE_W +: BYTE_W] = en_wr_i[l]
            ? wbyte_i
            : enable_q[l*BYTE_W +: BYTE_W];

        // R2: a lane neither written nor hit by the event holds its value
        a_r2_lane_kept: assert property (@(posedge clk) disable iff (rst)
            (!stat_wr_i[l] && !set_hp_i) |=> $stable(status_q[l*BYTE_W +: BYTE_W]));
        // R2: written ones are gone from that lane afterwards
        a_r2_lane_cleared: assert property (@(posedge clk) disable iff (rst)
            (stat_wr_i[l] && !set_hp_i) |=>
            ((status_q[l*BYTE_W +: BYTE_W] & $past(wbyte_i)) == '0));
        // R3: an enable lane not written holds its value
        a_r3_en_lane_kept: assert property (@(posedge clk) disable iff (rst)
            !en_wr_i[l] |=> $stable(enable_q[l*BYTE_W +: BYTE_W]));
    end

    // event set is applied after the clear so a coincident event wins (R10)
    always_comb begin
        status_d = status_lane_d;
        if (set_hp_i) status_d[HP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

    // R6 / R10: the event bit is set after any event, whatever the bus did
    a_r10_event_bit_set: assert property (@(posedge clk) disable iff (rst)
        set_hp_i |=> status_q[HP_BIT]);

endmodule

// File: rtl/hpn_slot_maps.sv
module hpn_slot_maps #(
    parameter int unsigned SLOTS = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_arrive_i,
    input  logic                     wr_depart_i,
    input  logic [SLOTS-1:0]         wdata_i,
    input  logic                     ev_valid_i,
    input  logic [$clog2(SLOTS)-1:0] ev_slot_i,
    input  logic                     ev_insert_i,
    output logic [SLOTS-1:0]         arrive_o,
    output logic [SLOTS-1:0]         depart_o
);
    logic [SLOTS-1:0] arrive_q, depart_q;
    logic [SLOTS-1:0] slot_bit;

    assign slot_bit = SLOTS'(1) << ev_slot_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            arrive_q <= '0;
            depart_q <= '0;
        end else if (ev_valid_i) begin
            arrive_q <= ev_insert_i ? slot_bit : '0;
            depart_q <= ev_insert_i ? '0 : slot_bit;
        end else begin
            if (wr_arrive_i) arrive_q <= wdata_i;
            if (wr_depart_i) depart_q <= wdata_i;
        end
    end

    assign arrive_o = arrive_q;
    assign depart_o = depart_q;

    // R6: exactly one bit across both maps after an event
    a_r6_single_bit: assert property (@(posedge clk) disable iff (rst)
        ev_valid_i |=> ($countones(arrive_q | depart_q) == 1));
    // R10: a same-cycle bus write to the opposite map is overridden
    a_r10_write_overridden: assert property (@(posedge clk) disable iff (rst)
        (ev_valid_i && !ev_insert_i && wr_arrive_i) |=> (arrive_q == '0));
    // R5: without an event, a write lands as a whole word
    a_r5_word_write: assert property (@(posedge clk) disable iff (rst)
        (!ev_valid_i && wr_depart_i) |=> (depart_q == $past(wdata_i)));

endmodule

// File: rtl/hpn_eject_decode.sv
module hpn_eject_decode #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic                      done_o,
    output logic [$clog2(DATA_W)-1:0] slot_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0] low_idx;
    logic             any_set;
    logic             done_q;
    logic [IDX_W-1:0] slot_q;

    // scan from the top so the last hit is the lowest set bit
    always_comb begin
        low_idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (wdata_i[i]) low_idx = IDX_W'(i);
        end
        any_set = |wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            slot_q <= '0;
        end else begin
            done_q <= wr_i && any_set;
            if (wr_i && any_set) slot_q <= low_idx;
        end
    end

    assign done_o = done_q;
    assign slot_o = slot_q;

    // R9: a zero word never completes
    a_r9_zero_silent: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (wdata_i == '0)) |=> !done_q);
    // R8: reported slot was set and nothing below it was
    a_r8_lowest_bit: assert property (@(posedge clk) disable iff (rst)
        (wr_i && any_set) |=>
        (done_q && ((($past(wdata_i) >> slot_q) & DATA_W'(1)) == DATA_W'(1))
         && (($past(wdata_i) & ((DATA_W'(1) << slot_q) - DATA_W'(1))) == '0)));

endmodule

// File: rtl/hotplug_notifier.sv
module hotplug_notifier #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned EV_W   = 16,
    parameter int unsigned HP_BIT = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      hp_valid,
    input  logic [$clog2(DATA_W)-1:0] hp_slot,
    input  logic                      hp_insert,
    output logic                      irq_pulse,
    output logic                      eject_done,
    output logic [$clog2(DATA_W)-1:0] eject_slot
);
    import hpn_pkg::*;

    localparam int unsigned LANES  = EV_W / BYTE_W;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    bus_dec_t            dec;
    logic [LANE_W-1:0]   lane;
    logic [LANES-1:0]    lane_bit;
    logic [LANES-1:0]    stat_wr, en_wr;
    logic [EV_W-1:0]     status, enable;
    logic [DATA_W-1:0]   arrive, depart;
    logic                irq_q;

    always_comb begin
        dec.sel  = decode_offset(8'(bus_addr), LANES);
        dec.wr   = bus_wr;
        lane     = bus_addr[LANE_W-1:0];
        lane_bit = LANES'(1) << lane;
        stat_wr  = (dec.wr && dec.sel == SEL_STAT)   ? lane_bit : '0;
        en_wr    = (dec.wr && dec.sel == SEL_ENABLE) ? lane_bit : '0;
    end

    hpn_event_regs #(.EV_W(EV_W), .HP_BIT(HP_BIT)) u_event_regs (
        .clk       (clk),
        .rst       (rst),
        .stat_wr_i (stat_wr),
        .en_wr_i   (en_wr),
        .wbyte_i   (bus_wdata[BYTE_W-1:0]),
        .set_hp_i  (hp_valid),
        .status_o  (status),
        .enable_o  (enable)
    );

    hpn_slot_maps #(.SLOTS(DATA_W)) u_slot_maps (
        .clk         (clk),
        .rst         (rst),
        .wr_arrive_i (dec.wr && dec.sel == SEL_ARRIVE),
        .wr_depart_i (dec.wr && dec.sel == SEL_DEPART),
        .wdata_i     (bus_wdata),
        .ev_valid_i  (hp_valid),
        .ev_slot_i   (hp_slot),
        .ev_insert_i (hp_insert),
        .arrive_o    (arrive),
        .depart_o    (depart)
    );

    hpn_eject_decode #(.DATA_W(DATA_W)) u_eject (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (dec.wr && dec.sel == SEL_EJECT),
        .wdata_i (bus_wdata),
        .done_o  (eject_done),
        .slot_o  (eject_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= hp_valid && enable[HP_BIT];
    end
    assign irq_pulse = irq_q;

    always_comb begin
        unique case (dec.sel)
            SEL_STAT:   bus_rdata = DATA_W'(8'(status >> (int'(lane) * BYTE_W)));
            SEL_ENABLE: bus_rdata = DATA_W'(8'(enable >> (int'(lane) * BYTE_W)));
            SEL_ARRIVE: bus_rdata = arrive;
            SEL_DEPART: bus_rdata = depart;
            default:    bus_rdata = '0;
        endcase
    end

    // R7: an interrupt only ever follows an event edge
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(hp_valid));
    // R7: an enabled event always raises the interrupt
    a_r7_irq_when_enabled: assert property (@(posedge clk) disable iff (rst)
        (hp_valid && enable[HP_BIT]) |=> irq_pulse);

endmodule

// File: tb/hotplug_notifier_bench.sv
module hotplug_notifier_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hp_valid = 1'b0;
    logic [4:0]  hp_slot = '0;
    logic        hp_insert = 1'b0;
    logic        irq_pulse;
    logic        eject_done;
    logic [4:0]  eject_slot;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic        cap_irq, cap_done;
    logic [4:0]  cap_slot;
    logic [15:0] exp_stat = '0;
    logic [15:0] exp_en = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hotplug_notifier u_hotplug_notifier (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_valid(hp_valid),
        .hp_slot(hp_slot), .hp_insert(hp_insert), .irq_pulse(irq_pulse),
        .eject_done(eject_done), .eject_slot(eject_slot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        cap_irq = irq_pulse; cap_done = eject_done; cap_slot = eject_slot;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic hp_event(input int slot, input bit ins, input bit with_wr,
                            input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        hp_valid = 1'b1; hp_slot = 5'(slot); hp_insert = ins;
        if (with_wr) begin bus_addr = a; bus_wr = 1'b1; bus_wdata = d; end
        @(posedge clk); #1;
        cap_irq = irq_pulse;
        @(negedge clk);
        hp_valid = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        check("R1 irq", 32'(irq_pulse), 0);
        check("R1 done", 32'(eject_done), 0);
        for (int a = 0; a < 4; a++) begin
            bus_read(5'(a), rd); check("R1 byte reg", rd, 0);
        end
        bus_read(5'h10, rd); check("R1 arrive", rd, 0);
        bus_read(5'h14, rd); check("R1 depart", rd, 0);

        // R3 enable lane sweep
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            v = 8'(k * 17);
            bus_write(5'd2, {24'hFFFFFF, v});  exp_en[7:0] = v;
            bus_read(5'd3, rd); check("R3 hi kept", rd, 32'(exp_en[15:8]));
            bus_write(5'd3, 32'(~v));          exp_en[15:8] = ~v;
            bus_read(5'd2, rd); check("R3 lo kept", rd, 32'(exp_en[7:0]));
            bus_read(5'd3, rd); check("R3 hi written", rd, 32'(exp_en[15:8]));
        end

        // R6 R7 event sweep across every slot
        for (int s = 0; s < 32; s++) begin
            bit ins, ena;
            ins = (s % 2) == 0;
            ena = (s % 3) != 0;
            bus_write(5'd2, ena ? 32'h02 : 32'h00);
            exp_en[7:0] = ena ? 8'h02 : 8'h00;
            hp_event(s, ins, 0, 5'd0, 0);
            exp_stat[1] = 1'b1;
            check("R7 irq pulse", 32'(cap_irq), 32'(ena));
            @(posedge clk); #1;
            check("R7 irq single cycle", 32'(irq_pulse), 0);
            bus_read(5'h10, rd); check("R6 arrive map", rd, ins ? (32'd1 << s) : 0);
            bus_read(5'h14, rd); check("R6 depart map", rd, ins ? 0 : (32'd1 << s));
            bus_read(5'd0, rd); check("R6 status bit1", rd, 32'(exp_stat[7:0]));
        end

        // R2 lane-local write-one-to-clear
        bus_write(5'd1, 32'hFF);
        bus_read(5'd0, rd); check("R2 other lane kept", rd, 32'h02);
        bus_read(5'd1, rd); check("R2 hi lane", rd, 0);
        bus_write(5'd0, 32'hFD);
        bus_read(5'd0, rd); check("R2 zero bit not cleared", rd, 32'h02);
        bus_write(5'd0, 32'h02);
        bus_read(5'd0, rd); check("R2 cleared", rd, 0);
        hp_event(3, 1, 0, 5'd0, 0);
        bus_write(5'd0, 32'hFFFF_FFFF);
        bus_read(5'd0, rd); check("R2 clear all", rd, 0);

        // R5 R4 bitmaps and unmapped reads
        for (int k = 0; k < 8; k++) begin
            logic [31:0] p;
            p = 32'hA5C3_0F01 ^ (32'(k) * 32'h1111_1111);
            bus_write(5'h10, p);
            bus_write(5'h14, ~p);
            bus_read(5'h10, rd); check("R5 arrive word", rd, p);
            bus_read(5'h14, rd); check("R5 depart word", rd, ~p);
        end
        bus_read(5'h08, rd); check("R4 unmapped 08", rd, 0);
        bus_read(5'h1C, rd); check("R4 unmapped 1C", rd, 0);
        bus_read(5'h18, rd); check("R8 eject reads zero", rd, 0);

        // R8 eject lowest-bit sweep
        for (int b = 0; b < 32; b++) begin
            logic [31:0] w, above;
            above = ~((32'd1 << (b + 1)) - 32'd1);
            if (b == 31) above = '0;
            w = (32'd1 << b) | (32'hDEAD_BEEF & above);
            bus_write(5'h18, w);
            check("R8 done", 32'(cap_done), 1);
            check("R8 slot", 32'(cap_slot), 32'(b));
        end
        @(posedge clk); #1;
        check("R8 done single cycle", 32'(eject_done), 0);

        // R9 zero eject
        bus_write(5'h18, 32'h0);
        check("R9 zero no done", 32'(cap_done), 0);
        bus_write(5'h18, 32'h100);
        bus_write(5'h18, 32'h0);
        check("R9 zero after nonzero", 32'(cap_done), 0);

        // R10 collisions
        bus_write(5'd2, 32'h02);
        hp_event(7, 0, 0, 5'd0, 0);
        hp_event(9, 1, 1, 5'd0, 32'h02);
        check("R10 irq with write", 32'(cap_irq), 1);
        bus_read(5'd0, rd); check("R10 status bit kept", rd, 32'h02);
        hp_event(5, 1, 1, 5'h10, 32'hFFFF_FFFF);
        bus_read(5'h10, rd); check("R10 map write overridden", rd, 32'd1 << 5);
        hp_event(6, 0, 1, 5'h10, 32'hFFFF_FFFF);
        bus_read(5'h10, rd); check("R10 arrive wiped", rd, 0);
        bus_read(5'h14, rd); check("R10 depart set", rd, 32'd1 << 6);

        finish_run();
    end

endmodule